// File: doc/BRIEF.md
# Eight-bit accumulator processor core

This block is a small multi-cycle processor with a single 8-bit accumulator, a carry/negative/zero status set, and two 256-byte memories. One holds instructions and the other holds data. Each instruction is one opcode byte. Direct and immediate forms add a second byte, which is either a data address or a literal argument. Every computed result goes back into the accumulator. Conditional control flow uses jump opcodes whose middle bits pick which flags must be set. The lowest four data addresses are kept free for I/O. Stores to them are shown at the store port but are not kept, and loads from them return zero.

Both memories sit inside the block. While `run` is low the core is frozen. A valid/ready load port then writes either memory, and `ld_ready` equals `!run`. The producer holds a beat until it sees ready, so it is back-pressured for as long as the core runs. While `run` is high the core fetches and executes. Each store it performs appears for exactly one cycle on a valid-only observation port. That port has no ready, because a store cannot be held back. The program counter, accumulator and flags come out as plain status pins.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is asserted and just after it, the program counter reads 0xFF, the accumulator and all three flags read 0, and the store port is idle.
- R2: Cycle counts per instruction are: inherent 2, immediate 3, store 3, jump 3, direct read 4. The program counter steps by one for each instruction byte read, wrapping from 0xFF to 0x00.
- R3: `ld_ready` equals `!run`. A beat with `ld_valid` and `ld_ready` high writes `ld_data` at `ld_addr`, into the data memory when `ld_to_data` is 1 and into the instruction memory when it is 0.
- R4: Load (0x82 direct, 0x81 immediate) copies the operand into the accumulator and sets N to bit 7 and Z to (result==0). Carry is kept.
- R5: Add (0x42/0x41), add-with-carry (0x4A/0x49) and increment (0x4C) write acc+operand+cin, with cin 0, C and 1 respectively. Carry takes the bit-8 carry out, and N and Z follow the result.
- R6: Subtract (0x52/0x51), subtract-with-carry (0x72/0x71) and decrement (0x44) compute acc + ~operand + cin, with cin 1, C and 1 respectively (decrement uses operand 1). Carry means no borrow.
- R7: Compare (0x62 direct, 0x61 immediate) sets C, N and Z exactly as subtract does and leaves the accumulator unchanged.
- R8: AND (0x5A/0x59), OR (0x5E/0x5D), XOR (0x56/0x55), invert (0x58) and clear (0x4F) update the accumulator, N and Z and keep carry. Carry-clear (0x40) and carry-set (0x48) change only carry.
- R9: Store (0xA2) raises `st_valid` for exactly the third cycle of the instruction, with `st_addr` set to the address byte and `st_data` set to the accumulator.
- R10: Data addresses 0x00 to 0x03 are not kept in memory. A store there still appears at the port, and a direct load from there returns 0.
- R11: Jump opcodes 11cnz000 take an address byte. Bit 5 demands C, bit 4 demands N and bit 3 demands Z. The jump is taken when every demanded flag is 1, so it is unconditional when none are demanded. A taken jump loads the program counter with the address byte.
- R12: Any opcode not listed above is a two-cycle, one-byte no-op that changes nothing but the program counter.
- R13: While `run` is low the program counter, accumulator, flags and controller state hold, and no store appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 executes, 0 freezes the core and opens the load port |
| ld_valid | input | 1 | Load beat present |
| ld_ready | output | 1 | Load beat accepted this cycle (equals !run) |
| ld_to_data | input | 1 | 1 targets data memory, 0 targets instruction memory |
| ld_addr | input | 8 | Load address |
| ld_data | input | 8 | Load byte |
| st_valid | output | 1 | A store executes this cycle |
| st_addr | output | 8 | Store address |
| st_data | output | 8 | Stored byte |
| pc_o | output | 8 | Program counter |
| acc_o | output | 8 | Accumulator |
| carry_o | output | 1 | Carry flag |
| neg_o | output | 1 | Negative flag |
| zero_o | output | 1 | Zero flag |

## Verification
The program counter, accumulator and flags are visible every cycle. A controller that picks the wrong state or skips an operand byte therefore shows up as a program-counter mismatch within one cycle of the fault. A wrong ALU setup or a wrong flag update shows on the accumulator or flag pins in the cycle after that instruction's execute state. Memory faults and I/O-window faults are hidden until a later direct load or store puts the byte on the accumulator or the store port. The bench therefore reads back each stored location, including one inside the I/O window.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_OPND,
    ST_MEMRD,
    ST_EXEC
  } cpu_state_e;

  typedef enum logic [1:0] {
    MODE_INH,
    MODE_IMM,
    MODE_DIR
  } addr_mode_e;

  typedef enum logic [3:0] {
    OP_NOP,
    OP_LDA,
    OP_STA,
    OP_ARITH,
    OP_CMP,
    OP_LOGIC,
    OP_CLRC,
    OP_CSET,
    OP_JMP
  } op_kind_e;

  typedef enum logic [1:0] {
    CIN_ZERO,
    CIN_ONE,
    CIN_FLAG
  } cin_sel_e;

  typedef enum logic [2:0] {
    FN_SUM,
    FN_AND,
    FN_OR,
    FN_XOR,
    FN_NOTA,
    FN_PASSB
  } alu_fn_e;

  typedef struct packed {
    op_kind_e   kind;
    addr_mode_e mode;
    cin_sel_e   cin;
    logic       b_zero;
    logic       b_inv;
    alu_fn_e    fn;
  } dec_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec
);

  always_comb begin
    dec        = '0;
    dec.kind   = OP_NOP;
    dec.mode   = MODE_INH;
    dec.cin    = CIN_ZERO;
    dec.fn     = FN_SUM;
    dec.b_zero = 1'b0;
    dec.b_inv  = 1'b0;
    if (opcode[7:6] == 2'b11) begin
      dec.kind = OP_JMP;
      dec.mode = MODE_DIR;
    end else begin
      unique case (opcode)
        8'h82: begin dec.kind = OP_LDA; dec.mode = MODE_DIR; end
        8'h81: begin dec.kind = OP_LDA; dec.mode = MODE_IMM; end
        8'hA2: begin dec.kind = OP_STA; dec.mode = MODE_DIR; end
        8'h42, 8'h41: begin
          dec.kind = OP_ARITH;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h4A, 8'h49: begin
          dec.kind = OP_ARITH; dec.cin = CIN_FLAG;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h4C: begin dec.kind = OP_ARITH; dec.b_zero = 1'b1; dec.cin = CIN_ONE; end
        8'h52, 8'h51: begin
          dec.kind = OP_ARITH; dec.b_inv = 1'b1; dec.cin = CIN_ONE;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h72, 8'h71: begin
          dec.kind = OP_ARITH; dec.b_inv = 1'b1; dec.cin = CIN_FLAG;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        // decrement: acc + 0xFF with no carry in equals acc - 1
        8'h44: begin dec.kind = OP_ARITH; dec.b_zero = 1'b1; dec.b_inv = 1'b1; end
        8'h62, 8'h61: begin
          dec.kind = OP_CMP; dec.b_inv = 1'b1; dec.cin = CIN_ONE;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h5A, 8'h59: begin
          dec.kind = OP_LOGIC; dec.fn = FN_AND;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h5E, 8'h5D: begin
          dec.kind = OP_LOGIC; dec.fn = FN_OR;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h56, 8'h55: begin
          dec.kind = OP_LOGIC; dec.fn = FN_XOR;
          dec.mode = opcode[1] ? MODE_DIR : MODE_IMM;
        end
        8'h58: begin dec.kind = OP_LOGIC; dec.fn = FN_NOTA; end
        8'h4F: begin dec.kind = OP_LOGIC; dec.fn = FN_PASSB; dec.b_zero = 1'b1; end
        8'h40: dec.kind = OP_CLRC;
        8'h48: dec.kind = OP_CSET;
        default: dec.kind = OP_NOP;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] bus,
  input  logic          b_zero,
  input  logic          b_inv,
  input  logic          cin,
  input  alu_fn_e       fn,
  output logic [DW-1:0] res,
  output logic          cout
);

  logic [DW-1:0] b_sel;
  logic [DW-1:0] b_eff;
  logic [DW:0]   sum;

  assign b_sel = b_zero ? '0 : bus;
  assign b_eff = b_inv ? ~b_sel : b_sel;
  assign sum   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};

  always_comb begin
    cout = sum[DW];
    unique case (fn)
      FN_SUM:   res = sum[DW-1:0];
      FN_AND:   res = a & b_eff;
      FN_OR:    res = a | b_eff;
      FN_XOR:   res = a ^ b_eff;
      FN_NOTA:  res = ~a;
      FN_PASSB: res = b_eff;
      default:  res = sum[DW-1:0];
    endcase
  end

endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int AW   = 8,
  parameter int DW   = 8,
  parameter int HOLE = 0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          hole_w;
  logic          hole_r;

  generate
    if (HOLE > 0) begin : g_hole
      localparam logic [AW-1:0] HOLE_TOP = AW'(HOLE);
      assign hole_w = (waddr < HOLE_TOP);
      assign hole_r = (raddr < HOLE_TOP);
    end else begin : g_flat
      assign hole_w = 1'b0;
      assign hole_r = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (we && !hole_w) mem[waddr] <= wdata;
  end

  assign rdata = hole_r ? '0 : mem[raddr];

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int            AW       = 8,
  parameter int            DW       = 8,
  parameter int            IO_SPAN  = 4,
  parameter logic [AW-1:0] RESET_PC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic          ld_to_data,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic          st_valid,
  output logic [AW-1:0] st_addr,
  output logic [DW-1:0] st_data,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] acc_o,
  output logic          carry_o,
  output logic          neg_o,
  output logic          zero_o
);

  cpu_state_e    state;
  logic [AW-1:0] pc;
  dec_t          dec_q;
  logic [2:0]    cond_q;
  logic [DW-1:0] opnd_q;
  logic [DW-1:0] mdr_q;
  logic [DW-1:0] acc;
  logic          flag_c, flag_n, flag_z;

  dec_t          dec_f;
  logic [DW-1:0] imem_rd, dmem_rd;
  logic          imem_we, dmem_we;
  logic [AW-1:0] dmem_waddr;
  logic [DW-1:0] dmem_wdata;
  logic          ld_fire;
  logic [DW-1:0] bus;
  logic          alu_cin;
  logic [DW-1:0] alu_res;
  logic          alu_cout;
  logic          jmp_taken;
  logic          in_exec;

  assign ld_ready = !run;
  assign ld_fire  = ld_valid && ld_ready;
  assign in_exec  = run && (state == ST_EXEC);

  // Memories: loads only while frozen, stores only while running
  assign imem_we    = ld_fire && !ld_to_data;
  assign st_valid   = in_exec && (dec_q.kind == OP_STA);
  assign dmem_we    = (ld_fire && ld_to_data) || st_valid;
  assign dmem_waddr = run ? AW'(opnd_q) : ld_addr;
  assign dmem_wdata = run ? acc : ld_data;

  acc_cpu_mem #(.AW(AW), .DW(DW), .HOLE(0)) u_imem (
    .clk(clk), .we(imem_we), .waddr(ld_addr), .wdata(ld_data),
    .raddr(pc), .rdata(imem_rd)
  );

  acc_cpu_mem #(.AW(AW), .DW(DW), .HOLE(IO_SPAN)) u_dmem (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr), .wdata(dmem_wdata),
    .raddr(AW'(opnd_q)), .rdata(dmem_rd)
  );

  acc_cpu_decode u_dec (.opcode(imem_rd), .dec(dec_f));

  // Operand bus: memory byte for direct mode, literal otherwise
  assign bus = (dec_q.mode == MODE_DIR) ? mdr_q : opnd_q;

  always_comb begin
    unique case (dec_q.cin)
      CIN_ONE:  alu_cin = 1'b1;
      CIN_FLAG: alu_cin = flag_c;
      default:  alu_cin = 1'b0;
    endcase
  end

  acc_cpu_alu #(.DW(DW)) u_alu (
    .a(acc), .bus(bus), .b_zero(dec_q.b_zero), .b_inv(dec_q.b_inv),
    .cin(alu_cin), .fn(dec_q.fn), .res(alu_res), .cout(alu_cout)
  );

  // cond_q = {c, n, z}: every demanded flag must be set
  assign jmp_taken = !((cond_q[2] && !flag_c) || (cond_q[1] && !flag_n) ||
                       (cond_q[0] && !flag_z));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_FETCH;
      pc     <= RESET_PC;
      dec_q  <= '0;
      cond_q <= '0;
      opnd_q <= '0;
      mdr_q  <= '0;
      acc    <= '0;
      flag_c <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else if (run) begin
      unique case (state)
        ST_FETCH: begin
          dec_q  <= dec_f;
          cond_q <= imem_rd[5:3];
          pc     <= pc + 1'b1;
          state  <= (dec_f.mode == MODE_INH) ? ST_EXEC : ST_OPND;
        end
        ST_OPND: begin
          opnd_q <= imem_rd;
          pc     <= pc + 1'b1;
          if (dec_q.mode == MODE_DIR && dec_q.kind != OP_STA && dec_q.kind != OP_JMP)
            state <= ST_MEMRD;
          else
            state <= ST_EXEC;
        end
        ST_MEMRD: begin
          mdr_q <= dmem_rd;
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          state <= ST_FETCH;
          unique case (dec_q.kind)
            OP_LDA: begin
              acc    <= bus;
              flag_n <= bus[DW-1];
              flag_z <= (bus == '0);
            end
            OP_ARITH: begin
              acc    <= alu_res;
              flag_c <= alu_cout;
              flag_n <= alu_res[DW-1];
              flag_z <= (alu_res == '0);
            end
            OP_CMP: begin
              flag_c <= alu_cout;
              flag_n <= alu_res[DW-1];
              flag_z <= (alu_res == '0);
            end
            OP_LOGIC: begin
              acc    <= alu_res;
              flag_n <= alu_res[DW-1];
              flag_z <= (alu_res == '0);
            end
            OP_CLRC: flag_c <= 1'b0;
            OP_CSET: flag_c <= 1'b1;
            OP_JMP:  if (jmp_taken) pc <= AW'(opnd_q);
            default: ;
          endcase
        end
        default: state <= ST_FETCH;
      endcase
    end
  end

  assign st_addr = AW'(opnd_q);
  assign st_data = acc;
  assign pc_o    = pc;
  assign acc_o   = acc;
  assign carry_o = flag_c;
  assign neg_o   = flag_n;
  assign zero_o  = flag_z;

  // R13: a frozen core keeps its architectural state
  a_r13_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pc) && $stable(acc) && $stable(flag_c) && $stable(flag_n) && $stable(flag_z)));

  // R13: no store while frozen
  a_r13_no_store_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !st_valid);

  // R9: a store is a single-cycle pulse
  a_r9_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |=> !st_valid);

  // R2: every fetch advances the program counter by one
  a_r2_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (run && state == ST_FETCH) |=> (pc == AW'($past(pc) + 1'b1)));

  // R7: compare never writes the accumulator
  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && dec_q.kind == OP_CMP) |=> $stable(acc));

  // R12: an undefined opcode leaves accumulator and flags alone
  a_r12_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && dec_q.kind == OP_NOP) |=> ($stable(acc) && $stable(flag_c) && $stable(flag_n) && $stable(flag_z)));

endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic       ld_to_data = 1'b0;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic       st_valid;
  logic [7:0] st_addr, st_data, pc_o, acc_o;
  logic       carry_o, neg_o, zero_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  acc_cpu_core dut_i (
    .clk(clk), .rst_n(rst_n), .run(run),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_to_data(ld_to_data),
    .ld_addr(ld_addr), .ld_data(ld_data),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .pc_o(pc_o), .acc_o(acc_o), .carry_o(carry_o), .neg_o(neg_o), .zero_o(zero_o)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0] m_imem [256];
  logic [7:0] m_dmem [256];
  logic [7:0] m_pc, m_acc, m_ir, m_opd, m_mdr;
  logic       m_c, m_n, m_z;
  int         m_step;
  string      m_tag = "R1";
  bit         m_live = 1'b0;

  function automatic int mode_of(input logic [7:0] op); // 0 inh, 1 imm, 2 dir
    if (op[7:6] == 2'b11) return 2;
    case (op)
      8'h82, 8'hA2, 8'h42, 8'h4A, 8'h52, 8'h72, 8'h5A, 8'h5E, 8'h56, 8'h62: return 2;
      8'h81, 8'h41, 8'h49, 8'h51, 8'h71, 8'h59, 8'h5D, 8'h55, 8'h61: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic set_nz(input int v);
    m_n = v[7];
    m_z = (v[7:0] == 8'h00);
  endtask

  task automatic model_exec();
    int v, s;
    v = (mode_of(m_ir) == 2) ? int'(m_mdr) : int'(m_opd);
    if (m_ir[7:6] == 2'b11) begin
      m_tag = "R11";
      if (!((m_ir[5] && !m_c) || (m_ir[4] && !m_n) || (m_ir[3] && !m_z))) m_pc = m_opd;
    end else begin
      case (m_ir)
        8'h81, 8'h82: begin m_tag = "R4"; m_acc = v[7:0]; set_nz(v); end
        8'h41, 8'h42, 8'h49, 8'h4A, 8'h4C: begin
          m_tag = "R5";
          if (m_ir == 8'h4C) s = int'(m_acc) + 1;
          else s = int'(m_acc) + v + ((m_ir[3]) ? int'(m_c) : 0);
          m_c = s[8]; m_acc = s[7:0]; set_nz(s);
        end
        8'h51, 8'h52, 8'h71, 8'h72, 8'h44, 8'h61, 8'h62: begin
          m_tag = (m_ir[7:4] == 4'h6) ? "R7" : "R6";
          if (m_ir == 8'h44) s = int'(m_acc) + 255;
          else s = int'(m_acc) + (255 - v) + ((m_ir[7:4] == 4'h7) ? int'(m_c) : 1);
          m_c = s[8]; set_nz(s);
          if (m_ir[7:4] != 4'h6) m_acc = s[7:0];
        end
        8'h59, 8'h5A: begin m_tag = "R8"; m_acc = m_acc & v[7:0]; set_nz(int'(m_acc)); end
        8'h5D, 8'h5E: begin m_tag = "R8"; m_acc = m_acc | v[7:0]; set_nz(int'(m_acc)); end
        8'h55, 8'h56: begin m_tag = "R8"; m_acc = m_acc ^ v[7:0]; set_nz(int'(m_acc)); end
        8'h58: begin m_tag = "R8"; m_acc = ~m_acc; set_nz(int'(m_acc)); end
        8'h4F: begin m_tag = "R8"; m_acc = 8'h00; set_nz(0); end
        8'h40: begin m_tag = "R8"; m_c = 1'b0; end
        8'h48: begin m_tag = "R8"; m_c = 1'b1; end
        8'hA2: begin m_tag = (m_opd < 8'd4) ? "R10" : "R9"; if (m_opd >= 8'd4) m_dmem[m_opd] = m_acc; end
        default: m_tag = "R12";
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 8'hFF; m_acc = 8'h00; m_c = 0; m_n = 0; m_z = 0;
      m_step = 0; m_ir = 8'h00; m_opd = 8'h00; m_mdr = 8'h00; m_live = 1'b1;
    end else if (run) begin
      case (m_step)
        0: begin m_ir = m_imem[m_pc]; m_pc = m_pc + 8'd1; m_step = (mode_of(m_ir) == 0) ? 3 : 1; end
        1: begin
          m_opd = m_imem[m_pc]; m_pc = m_pc + 8'd1;
          m_step = (mode_of(m_ir) == 2 && m_ir != 8'hA2 && m_ir[7:6] != 2'b11) ? 2 : 3;
        end
        2: begin m_mdr = (m_opd < 8'd4) ? 8'h00 : m_dmem[m_opd]; m_step = 3; end
        default: begin model_exec(); m_step = 0; end
      endcase
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // lockstep compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && m_live && !done) begin
      logic exp_st;
      check("R3", "ld_ready", int'(ld_ready), int'(!run));
      check((m_tag == "R11") ? "R11" : "R2", "pc", int'(pc_o), int'(m_pc));
      check(m_tag, "acc", int'(acc_o), int'(m_acc));
      check(m_tag, "flags", int'({carry_o, neg_o, zero_o}), int'({m_c, m_n, m_z}));
      exp_st = run && (m_step == 3) && (m_ir == 8'hA2);
      check(run ? "R9" : "R13", "st_valid", int'(st_valid), int'(exp_st));
      if (exp_st) begin
        check("R9", "st_addr", int'(st_addr), int'(m_opd));
        check("R9", "st_data", int'(st_data), int'(m_acc));
      end
    end
  end

  task automatic load(input bit to_data, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_to_data = to_data; ld_addr = a; ld_data = d;
    if (to_data) begin if (a >= 8'd4) m_dmem[a] = d; end
    else m_imem[a] = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic put_prog(input logic [7:0] a, input logic [7:0] d);
    load(1'b0, a, d);
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    logic [7:0] prog [$];
    logic [7:0] pc0;
    for (int i = 0; i < 256; i++) begin m_imem[i] = 8'h00; m_dmem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "pc reset", int'(pc_o), 8'hFF);
    check("R1", "acc reset", int'(acc_o), 0);
    check("R1", "flags reset", int'({carry_o, neg_o, zero_o}), 0);
    check("R1", "store idle", int'(st_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "pc after reset", int'(pc_o), 8'hFF);
    // clear both memories through the load port (R3)
    for (int i = 0; i < 256; i++) begin load(1'b0, 8'(i), 8'h00); load(1'b1, 8'(i), 8'h00); end
    load(1'b1, 8'h30, 8'h80);
    load(1'b1, 8'h31, 8'h0F);
    // reset vector: unconditional jump to 0x10, address byte wraps to 0x00 (R2, R11)
    put_prog(8'hFF, 8'hC0);
    put_prog(8'h00, 8'h10);
    prog = '{8'h81, 8'h05, 8'hA2, 8'h20, 8'h41, 8'hFC, 8'h49, 8'h00, 8'h4C, 8'h44,
             8'h51, 8'h03, 8'h71, 8'h00, 8'h61, 8'hFE, 8'hE8, 8'h40};
    pc0 = 8'h10;
    foreach (prog[i]) put_prog(pc0 + 8'(i), prog[i]);
    prog = '{8'h82, 8'h20, 8'h42, 8'h30, 8'h5A, 8'h31, 8'h5D, 8'h30, 8'h55, 8'hFF,
             8'h58, 8'hA2, 8'h02, 8'h82, 8'h02, 8'hD0, 8'h70, 8'h07, 8'hFF, 8'h48,
             8'h62, 8'h20, 8'h40, 8'h4F, 8'hF8, 8'h60, 8'h56, 8'h31, 8'h72, 8'h30,
             8'h4A, 8'h31, 8'h52, 8'h31, 8'hA2, 8'h40, 8'h82, 8'h40, 8'hC0, 8'h10};
    pc0 = 8'h40;
    foreach (prog[i]) put_prog(pc0 + 8'(i), prog[i]);
    put_prog(8'h60, 8'hC0);
    put_prog(8'h61, 8'h70);
    put_prog(8'h70, 8'h59); put_prog(8'h71, 8'hF0);
    put_prog(8'h72, 8'hC0); put_prog(8'h73, 8'h60);
    // execute, freeze mid-program (R13), patch a data byte, resume
    run_cycles(37);
    repeat (6) @(negedge clk);
    load(1'b1, 8'h31, 8'h3C);
    run_cycles(160);
    // second reset returns to the reset vector (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "pc re-reset", int'(pc_o), 8'hFF);
    check("R1", "acc re-reset", int'(acc_o), 0);
    rst_n = 1'b1;
    run_cycles(60);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule